// File: doc/BRIEF.md
# Banked Serial-Port Configuration Register Space

This block holds the configuration registers of a two-channel serial-port function. Software reaches them through two byte-wide ports. A write to the index port latches an 8-bit register address. Reads and writes on the data port then act on the register at that address. A logical-device number register chooses which per-channel bank the banked addresses refer to. The bus front end decodes host cycles into single-cycle strobes for this block. Another block recognises the unlock sequence and drives the configuration-mode flag.

Every register that is not implemented reads back as zero and ignores writes. This applies across the whole 8-bit address range, with no aliasing. The per-channel settings are the serial-IRQ enable and the 2-bit clock pre-divide select. They are driven out as registered signals to the two serial-port cores.

Top module: `sio_cfg_space`

## Requirements
- R1: After reset, rdata_o is 00h, every irq_en_o bit is 1, every div_sel_o field is 00, and the logical-device register is 00h.
- R2: All eight index bits are decoded. Any address other than 07h, 20h, 21h, 28h and 29h reads 00h and ignores writes. Examples are 27h, 87h and A8h.
- R3: Address 07h is a full 8-bit read/write logical-device register. Values 0 and 1 select bank 0 and bank 1. Any other value is kept for readback, but banked accesses go to bank 0.
- R4: Address 20h reads 00h and address 21h reads 01h. Writes to either one change nothing.
- R5: Address 28h bit 0 is the read/write serial-IRQ enable of the selected bank, driven on irq_en_o[bank]. Bit 1 reads the fixed IRQ-mode parameter CONT_MODE (default 0 = quiet). Bits 7:2 read 0.
- R6: Address 29h bits 3:2 are the read/write pre-divide select of the selected bank, driven on div_sel_o[2*bank+1:2*bank]. The codes are 00 = /1, 01 = /8 and 10 = /26. Bit 1 reads 1 and bits 7:4 and 0 read 0. A write with bits 3:2 = 11 leaves the field unchanged.
- R7: A write to 28h or 29h changes the outputs of the selected bank only.
- R8: While cfg_mode_i is 0, a data read returns 00h and a data write changes nothing. Index writes are accepted in either mode, and the index keeps its value.
- R9: Read data appears on rdata_o one cycle after the data_rd_i strobe and holds until the next strobe. A data write changes the outputs one cycle after its strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_mode_i | input | 1 | Configuration mode active |
| idx_wr_i | input | 1 | Index port write strobe |
| data_wr_i | input | 1 | Data port write strobe |
| data_rd_i | input | 1 | Data port read strobe |
| wdata_i | input | 8 | Write data for the index or data port |
| rdata_o | output | 8 | Data port read result |
| irq_en_o | output | NDEV | Serial-IRQ enable per channel |
| div_sel_o | output | 2*NDEV | Pre-divide select per channel, 2 bits each |

## Verification
Each result has its own latency. A data read is due on rdata_o one edge after its strobe. A data write shows on irq_en_o and div_sel_o one edge after its strobe. An index write affects only later accesses. The bench drives every strobe for exactly one cycle starting at a falling edge. It deasserts the strobe at the next falling edge and compares there, so exactly one rising edge lies between stimulus and sample. One directed check samples again a cycle later to confirm that rdata_o holds.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;
  localparam logic [7:0] A_LDN  = 8'h07;
  localparam logic [7:0] A_ID   = 8'h20;
  localparam logic [7:0] A_REV  = 8'h21;
  localparam logic [7:0] A_IRQ  = 8'h28;
  localparam logic [7:0] A_CLK  = 8'h29;
  localparam logic [7:0] ID_VAL  = 8'h00;
  localparam logic [7:0] REV_VAL = 8'h01;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_LDN, SEL_ID, SEL_REV, SEL_IRQ, SEL_CLK
  } reg_sel_e;

  function automatic reg_sel_e decode(input logic [7:0] a);
    case (a)
      A_LDN:   return SEL_LDN;
      A_ID:    return SEL_ID;
      A_REV:   return SEL_REV;
      A_IRQ:   return SEL_IRQ;
      A_CLK:   return SEL_CLK;
      default: return SEL_NONE;
    endcase
  endfunction
endpackage

// File: rtl/sio_cfg_byte_reg.sv
module sio_cfg_byte_reg #(
  parameter logic [7:0] RST_VAL = 8'h00
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       we_i,
  input  logic [7:0] d_i,
  output logic [7:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= RST_VAL;
    else if (we_i) q_o <= d_i;
  end
endmodule

// File: rtl/sio_cfg_bank.sv
module sio_cfg_bank (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_irq_i,
  input  logic       wr_clk_i,
  input  logic [7:0] wdata_i,
  output logic       irq_en_o,
  output logic [1:0] div_sel_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_en_o  <= 1'b1;
      div_sel_o <= 2'b00;
    end else begin
      if (wr_irq_i) irq_en_o <= wdata_i[0];
      // code 11 is reserved: keep the previous select
      if (wr_clk_i && (wdata_i[3:2] != 2'b11)) div_sel_o <= wdata_i[3:2];
    end
  end
endmodule

// File: rtl/sio_cfg_rdmux.sv
module sio_cfg_rdmux
  import sio_cfg_pkg::*;
#(
  parameter bit CONT_MODE = 1'b0
) (
  input  reg_sel_e   sel_i,
  input  logic [7:0] ldn_i,
  input  logic       irq_en_i,
  input  logic [1:0] div_sel_i,
  output logic [7:0] rdata_o
);
  always_comb begin
    case (sel_i)
      SEL_LDN: rdata_o = ldn_i;
      SEL_ID:  rdata_o = ID_VAL;
      SEL_REV: rdata_o = REV_VAL;
      SEL_IRQ: rdata_o = {6'b0, CONT_MODE, irq_en_i};
      SEL_CLK: rdata_o = {4'b0, div_sel_i, 2'b10};
      default: rdata_o = 8'h00;
    endcase
  end
endmodule

// File: rtl/sio_cfg_space.sv
module sio_cfg_space
  import sio_cfg_pkg::*;
#(
  parameter int unsigned NDEV      = 2,
  parameter bit          CONT_MODE = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_mode_i,
  input  logic              idx_wr_i,
  input  logic              data_wr_i,
  input  logic              data_rd_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  output logic [NDEV-1:0]   irq_en_o,
  output logic [2*NDEV-1:0] div_sel_o
);
  localparam int unsigned BW = (NDEV > 1) ? $clog2(NDEV) : 1;

  logic [7:0]    idx_q;
  logic [7:0]    ldn_q;
  logic [7:0]    rd_mux;
  logic [BW-1:0] bank;
  reg_sel_e      sel;
  logic          wr_ok;
  logic          irq_cur;
  logic [1:0]    div_cur;

  assign sel   = decode(idx_q);
  assign wr_ok = cfg_mode_i && data_wr_i;
  // out-of-range device numbers fall back to bank 0
  assign bank  = (ldn_q < 8'(NDEV)) ? ldn_q[BW-1:0] : '0;

  sio_cfg_byte_reg #(.RST_VAL(8'h00)) u_idx (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(idx_wr_i), .d_i(wdata_i), .q_o(idx_q)
  );

  sio_cfg_byte_reg #(.RST_VAL(8'h00)) u_ldn (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(wr_ok && (sel == SEL_LDN)),
    .d_i(wdata_i), .q_o(ldn_q)
  );

  for (genvar d = 0; d < NDEV; d++) begin : g_bank
    logic hit;
    assign hit = wr_ok && (bank == BW'(d));
    sio_cfg_bank u_bank (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_irq_i  (hit && (sel == SEL_IRQ)),
      .wr_clk_i  (hit && (sel == SEL_CLK)),
      .wdata_i   (wdata_i),
      .irq_en_o  (irq_en_o[d]),
      .div_sel_o (div_sel_o[2*d+1:2*d])
    );
  end

  assign irq_cur = irq_en_o[bank];
  assign div_cur = div_sel_o[2*bank +: 2];

  sio_cfg_rdmux #(.CONT_MODE(CONT_MODE)) u_rdmux (
    .sel_i(sel), .ldn_i(ldn_q), .irq_en_i(irq_cur), .div_sel_i(div_cur),
    .rdata_o(rd_mux)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        rdata_o <= 8'h00;
    else if (data_rd_i) rdata_o <= cfg_mode_i ? rd_mux : 8'h00;
  end
endmodule

// File: rtl/sio_cfg_space_chk.sv
module sio_cfg_space_chk
  import sio_cfg_pkg::*;
#(
  parameter int unsigned NDEV = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cfg_mode_i,
  input logic              data_wr_i,
  input logic              data_rd_i,
  input logic [7:0]        rdata_o,
  input logic [NDEV-1:0]   irq_en_o,
  input logic [2*NDEV-1:0] div_sel_o,
  input logic [7:0]        idx_q
);
  logic [NDEV-1:0]   prev_irq;
  logic [2*NDEV-1:0] prev_div;
  logic [NDEV-1:0]   chg;
  logic [NDEV-1:0]   bad_div;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_irq <= '1;
      prev_div <= '0;
    end else begin
      prev_irq <= irq_en_o;
      prev_div <= div_sel_o;
    end
  end

  for (genvar d = 0; d < NDEV; d++) begin : g_c
    assign chg[d] = (irq_en_o[d] != prev_irq[d]) ||
                    (div_sel_o[2*d+1:2*d] != prev_div[2*d+1:2*d]);
    assign bad_div[d] = (div_sel_o[2*d+1:2*d] == 2'b11);
  end

  a_r2_unmapped_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_mode_i && data_rd_i && decode(idx_q) == SEL_NONE) |=> rdata_o == 8'h00);

  a_r6_no_reserved_div: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad_div == '0);

  a_r7_one_bank: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(chg) <= 1);

  a_r8_locked_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_mode_i && data_rd_i) |=> rdata_o == 8'h00);

  a_r8_fields_need_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cfg_mode_i && data_wr_i) |=> ($stable(irq_en_o) && $stable(div_sel_o)));

  a_r9_rdata_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !data_rd_i |=> $stable(rdata_o));
endmodule

bind sio_cfg_space sio_cfg_space_chk #(.NDEV(NDEV)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cfg_mode_i(cfg_mode_i),
  .data_wr_i(data_wr_i), .data_rd_i(data_rd_i), .rdata_o(rdata_o),
  .irq_en_o(irq_en_o), .div_sel_o(div_sel_o), .idx_q(idx_q)
);

// File: tb/sio_cfg_space_tb_top.sv
module sio_cfg_space_tb_top;
  localparam int unsigned NDEV = 2;
  localparam time PERIOD = 10ns;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic cfg_mode = 1'b0, idx_wr = 1'b0, data_wr = 1'b0, data_rd = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic [NDEV-1:0] irq_en;
  logic [2*NDEV-1:0] div_sel;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [7:0] m_idx, m_ldn;
  logic [NDEV-1:0] m_irq;
  logic [2*NDEV-1:0] m_div;

  always #(PERIOD/2) clk = ~clk;

  sio_cfg_space #(.NDEV(NDEV), .CONT_MODE(1'b0)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .cfg_mode_i(cfg_mode), .idx_wr_i(idx_wr),
    .data_wr_i(data_wr), .data_rd_i(data_rd), .wdata_i(wdata),
    .rdata_o(rdata), .irq_en_o(irq_en), .div_sel_o(div_sel)
  );

  function automatic int m_bank();
    return (m_ldn < 8'(NDEV)) ? int'(m_ldn) : 0;
  endfunction

  function automatic logic [7:0] exp_read();
    int b = m_bank();
    case (m_idx)
      8'h07:   return m_ldn;
      8'h20:   return 8'h00;
      8'h21:   return 8'h01;
      8'h28:   return {6'b0, 1'b0, m_irq[b]};
      8'h29:   return {4'b0, m_div[2*b +: 2], 2'b10};
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic chk_outs(input string tag);
    chk(tag, 16'(irq_en), 16'(m_irq));
    chk(tag, 16'(div_sel), 16'(m_div));
  endtask

  task automatic do_idx(input logic [7:0] a);
    idx_wr = 1'b1; wdata = a;
    @(negedge clk); idx_wr = 1'b0;
    m_idx = a;
  endtask

  task automatic do_wr(input logic [7:0] d);
    int b = m_bank();
    data_wr = 1'b1; wdata = d;
    @(negedge clk); data_wr = 1'b0;
    if (cfg_mode) begin
      case (m_idx)
        8'h07: m_ldn = d;
        8'h28: m_irq[b] = d[0];
        8'h29: if (d[3:2] != 2'b11) m_div[2*b +: 2] = d[3:2];
        default: ;
      endcase
    end
    chk("R7 outputs after write", 16'(irq_en), 16'(m_irq));
    chk("R6 R7 div after write", 16'(div_sel), 16'(m_div));
  endtask

  task automatic do_rd(input string tag);
    logic [7:0] e = cfg_mode ? exp_read() : 8'h00;
    data_rd = 1'b1;
    @(negedge clk); data_rd = 1'b0;
    chk(tag, 16'(rdata), 16'(e));
  endtask

  initial begin
    #(PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog act=hung exp=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    m_idx = 0; m_ldn = 0; m_irq = '1; m_div = '0;
    repeat (3) @(negedge clk);
    chk("R1 rdata reset", 16'(rdata), 16'h0);
    chk_outs("R1 fields reset");
    rst_ni = 1'b1;
    @(negedge clk);
    cfg_mode = 1'b1;

    do_idx(8'h07); do_rd("R1 R3 ldn reset 00");
    do_idx(8'h20); do_rd("R4 id 00"); do_wr(8'hFF); do_rd("R4 id write ignored");
    do_idx(8'h21); do_rd("R4 rev 01"); do_wr(8'h00); do_rd("R4 rev write ignored");
    do_idx(8'h28); do_rd("R5 irq reg reset 01");
    do_wr(8'hFE); do_rd("R5 irq cleared bank0, bits7:1");
    do_idx(8'h29); do_rd("R6 clk reg reset 02");
    do_wr(8'h04); do_rd("R6 div 01");
    do_wr(8'h0C); do_rd("R6 code 11 ignored");
    do_wr(8'hF8); do_rd("R6 div 10, reserved bits 0");
    @(negedge clk);
    chk("R9 rdata holds", 16'(rdata), 16'(exp_read()));
    do_idx(8'h07); do_wr(8'h01); do_rd("R3 ldn 01");
    do_idx(8'h28); do_rd("R7 bank1 irq untouched");
    do_wr(8'h00); chk_outs("R7 bank1 irq only");
    do_idx(8'h29); do_wr(8'h04); do_rd("R7 bank1 div");
    do_idx(8'h07); do_wr(8'h05); do_rd("R3 ldn keeps 05");
    do_idx(8'h29); do_rd("R3 ldn 05 maps bank0");
    do_wr(8'h00); chk_outs("R3 write goes to bank0");
    do_idx(8'h87); do_wr(8'hFF); do_rd("R2 87 reads 0"); chk_outs("R2 87 write ignored");
    do_idx(8'hA8); do_wr(8'h01); do_rd("R2 A8 no alias of 28");
    do_idx(8'h27); do_rd("R2 27 reads 0");
    do_idx(8'h28);
    cfg_mode = 1'b0;
    do_rd("R8 locked read 00"); do_wr(8'h01); chk_outs("R8 locked write ignored");
    do_idx(8'h21);
    cfg_mode = 1'b1;
    do_rd("R8 index taken while locked");

    for (int i = 0; i < 600; i++) begin
      int op = $urandom_range(0, 9);
      cfg_mode = ($urandom_range(0, 9) < 8);
      if (op < 3) begin
        int k = $urandom_range(0, 6);
        logic [7:0] a;
        case (k)
          0: a = 8'h07; 1: a = 8'h20; 2: a = 8'h21;
          3, 4: a = 8'h28; 5: a = 8'h29;
          default: a = 8'($urandom);
        endcase
        do_idx(a);
      end else if (op < 6) begin
        logic [7:0] d = 8'($urandom);
        if (m_idx == 8'h07) d = 8'($urandom_range(0, 2));
        do_wr(d);
      end else begin
        do_rd("R2 R5 R6 R8 random read");
      end
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule